// File: doc/BRIEF.md
# Configurable-Format UART Transmitter

This block turns bytes into asynchronous serial frames on a single TX line. A 7-bit control byte sets the frame format: data width of 5 to 8 bits, whether a parity bit is sent and how it is formed, the stop length, and a break override. The block takes data through a valid/ready handshake. It times every bit from a 16x oversampling tick supplied from outside, so the baud rate is set wherever that tick is made.

A frame is a low start bit, then the data bits LSB first, then an optional parity bit, then a high stop period. The line idles high. Width, parity and stop settings are latched when a byte is accepted, so the control byte can change while a frame is on the line without harming it. The break control does not wait for a frame boundary. While it is set, the line is forced low, and the frame timing carries on underneath.

Top module: `uart_frame_tx`

## Requirements
- R1: ctrl_i[1:0] picks the data width: 00=5, 01=6, 10=7, 11=8 bits. Data bits go out LSB first, and bits above the chosen width are not sent.
- R2: The line is high when idle. Each frame begins with one low start bit. The start, data and parity bits each last 16 ticks of tick_i.
- R3: With ctrl_i[2]=0 the stop period is 16 ticks. With ctrl_i[2]=1 it is 24 ticks for a 5-bit width and 32 ticks for 6, 7 or 8 bits.
- R4: When ctrl_i[3]=0, no parity bit is sent, whatever ctrl_i[5:4] holds.
- R5: ctrl_i[5:3]=001 sends odd parity and 011 sends even parity. Both are computed only over the data bits inside the chosen width.
- R6: ctrl_i[5:3]=101 sends a parity bit that is always 1. ctrl_i[5:3]=111 sends one that is always 0.
- R7: While ctrl_i[6]=1, tx_o is 0 in the same cycle, both when idle and mid-frame. Frame timing continues while break is set, and tx_o returns to the frame's level once the bit clears.
- R8: Data and format are captured on the clock edge that accepts a byte. Later changes to data_i or ctrl_i[5:0] do not change the frame in flight.
- R9: ready_o is high only when no frame is in progress. A byte is accepted on a clock edge where valid_i and ready_o are both high. busy_o is high from the cycle after acceptance until the edge of the last stop tick. valid_i has no effect while busy_o is high.
- R10: During reset, tx_o=1, busy_o=0 and ready_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| ctrl_i | input | 7 | Format control: width [1:0], stop [2], parity [5:3], break [6] |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | data_i holds a byte to send |
| ready_o | output | 1 | Transmitter idle; a byte can be accepted |
| tx_o | output | 1 | Serial line |
| busy_o | output | 1 | A frame is in progress |

## Verification
The reference model builds each frame as a per-tick list of line levels and compares tx_o, busy_o and ready_o with it on every cycle. It uses a 5-bit word whose unsent upper bits would change the parity. A design that formed parity over the whole byte would send the wrong parity bit there. It checks the 24-tick stop against the 32-tick one, which catches a design that gives 5-bit words two full stop bits. It changes the format and raises valid_i in the middle of a frame: a design that read the control byte live would alter the frame, and one that accepted bytes while busy would stretch it. It also asserts break both mid-frame and while idle, which catches a break that waited for a frame boundary or stopped the bit timing.

// File: rtl/uft_pkg.sv
package uft_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} tx_state_e;
  typedef enum logic [1:0] {PAR_ODD, PAR_EVEN, PAR_ONE, PAR_ZERO} par_kind_e;

  typedef struct packed {
    logic [2:0] last_idx;
    logic       par_en;
    par_kind_e  par_kind;
    logic       stop_long;
    logic       stop_half;
  } fmt_t;
endpackage

// File: rtl/uft_fmt_decode.sv
module uft_fmt_decode
  import uft_pkg::*;
(
  input  logic [5:0] ctrl_i,
  output fmt_t       fmt_o
);
  always_comb begin
    fmt_o.last_idx  = 3'd4 + {1'b0, ctrl_i[1:0]};
    fmt_o.par_en    = ctrl_i[3];
    fmt_o.par_kind  = par_kind_e'(ctrl_i[5:4]);
    fmt_o.stop_half = ctrl_i[2] && (ctrl_i[1:0] == 2'b00);
    fmt_o.stop_long = ctrl_i[2] && (ctrl_i[1:0] != 2'b00);
  end
endmodule

// File: rtl/uft_parity_gen.sv
module uft_parity_gen
  import uft_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [2:0]        last_idx_i,
  input  par_kind_e         kind_i,
  output logic              par_o
);
  logic [DATA_W-1:0] masked;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = data_i[i] & (i <= int'(last_idx_i));
  end

  logic xr;
  assign xr = ^masked;

  always_comb begin
    unique case (kind_i)
      PAR_ODD:  par_o = ~xr;
      PAR_EVEN: par_o = xr;
      PAR_ONE:  par_o = 1'b1;
      default:  par_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/uft_tick_timer.sv
module uft_tick_timer #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [CW-1:0] last_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || done_o) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [6:0]        ctrl_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              tx_o,
  output logic              busy_o
);
  localparam int CW = $clog2(2 * TICKS_PER_BIT);
  localparam logic [CW-1:0] BIT_LAST  = CW'(TICKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'((TICKS_PER_BIT * 3) / 2 - 1);
  localparam logic [CW-1:0] LONG_LAST = CW'(2 * TICKS_PER_BIT - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [2:0]        idx_q, last_idx_q;
  logic              par_en_q, par_q;
  logic [CW-1:0]     stop_last_q;

  fmt_t fmt_d;
  logic par_d, accept, done, line;
  logic [CW-1:0] timer_last;

  uft_fmt_decode u_fmt (.ctrl_i(ctrl_i[5:0]), .fmt_o(fmt_d));

  uft_parity_gen #(.DATA_W(DATA_W)) u_par (
    .data_i(data_i), .last_idx_i(fmt_d.last_idx), .kind_i(fmt_d.par_kind), .par_o(par_d)
  );

  assign accept     = valid_i && (state_q == ST_IDLE);
  assign timer_last = (state_q == ST_STOP) ? stop_last_q : BIT_LAST;

  uft_tick_timer #(.CW(CW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(accept), .tick_i(tick_i),
    .last_i(timer_last), .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      shreg_q     <= '0;
      idx_q       <= '0;
      last_idx_q  <= '0;
      par_en_q    <= 1'b0;
      par_q       <= 1'b0;
      stop_last_q <= BIT_LAST;
    end else if (accept) begin
      state_q     <= ST_START;
      shreg_q     <= data_i;
      idx_q       <= '0;
      last_idx_q  <= fmt_d.last_idx;
      par_en_q    <= fmt_d.par_en;
      par_q       <= par_d;
      stop_last_q <= fmt_d.stop_half ? HALF_LAST : (fmt_d.stop_long ? LONG_LAST : BIT_LAST);
    end else if (done) begin
      unique case (state_q)
        ST_START: state_q <= ST_DATA;
        ST_DATA: begin
          shreg_q <= shreg_q >> 1;
          if (idx_q == last_idx_q) state_q <= par_en_q ? ST_PAR : ST_STOP;
          else                     idx_q   <= idx_q + 1'b1;
        end
        ST_PAR:  state_q <= ST_STOP;
        ST_STOP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg_q[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  // break acts live, independent of frame state
  assign tx_o    = line & ~ctrl_i[6];
  assign ready_o = (state_q == ST_IDLE);
  assign busy_o  = ~ready_o;
endmodule

// File: rtl/uft_checker.sv
module uft_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic brk_i,
  input logic valid_i,
  input logic ready_o,
  input logic tx_o,
  input logic busy_o
);
  assert_break_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !tx_o);

  assert_idle_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !brk_i) |-> tx_o);

  assert_ready_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o != busy_o);

  assert_accept_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (busy_o && !tx_o));

  assert_hold_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> busy_o);

  assert_hold_line_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !brk_i) |=> (brk_i || $stable(tx_o)));
endmodule

bind uart_frame_tx uft_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .brk_i(ctrl_i[6]),
  .valid_i(valid_i), .ready_o(ready_o), .tx_o(tx_o), .busy_o(busy_o)
);

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;
  localparam int TPB = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [6:0] ctrl_i = '0;
  logic [7:0] data_i = '0;
  logic       valid_i = 1'b0;
  logic       ready_o, tx_o, busy_o;

  int checks = 0;
  int fails = 0;
  bit cmp_en = 1'b0;
  string cur_req = "R10";
  bit q[$];

  uart_frame_tx uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ctrl_i(ctrl_i),
    .data_i(data_i), .valid_i(valid_i), .ready_o(ready_o), .tx_o(tx_o), .busy_o(busy_o)
  );

  always #4 clk_i = ~clk_i;

  initial begin
    int k = 0;
    forever begin
      @(negedge clk_i);
      tick_i = (k % 3 == 2);
      k++;
    end
  end

  function automatic void push_level(bit lvl, int n);
    for (int i = 0; i < n; i++) q.push_back(lvl);
  endfunction

  function automatic void push_frame(logic [7:0] d, logic [6:0] c);
    int wl = 5 + int'(c[1:0]);
    int ones = 0;
    bit p;
    push_level(1'b0, TPB);
    for (int i = 0; i < wl; i++) begin
      push_level(d[i], TPB);
      if (d[i]) ones++;
    end
    if (c[3]) begin
      case (c[5:4])
        2'b00:   p = (ones % 2 == 0);
        2'b01:   p = (ones % 2 == 1);
        2'b10:   p = 1'b1;
        default: p = 1'b0;
      endcase
      push_level(p, TPB);
    end
    if (!c[2])       push_level(1'b1, TPB);
    else if (wl == 5) push_level(1'b1, TPB + TPB / 2);
    else             push_level(1'b1, 2 * TPB);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q.delete();
    else if (q.size() > 0) begin
      if (tick_i) void'(q.pop_front());
    end else if (valid_i) push_frame(data_i, ctrl_i);
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (cmp_en && rst_ni) begin
        logic etx;
        etx = ctrl_i[6] ? 1'b0 : ((q.size() > 0) ? q[0] : 1'b1);
        check(cur_req, "tx_o", tx_o, etx);
        check(cur_req, "busy_o", busy_o, q.size() > 0);
        check(cur_req, "ready_o", ready_o, q.size() == 0);
      end
    end
  end

  task automatic send(logic [7:0] d, logic [6:0] c);
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    data_i = d; ctrl_i = c; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    repeat (5) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10", "tx_o", tx_o, 1'b1);
    check("R10", "busy_o", busy_o, 1'b0);
    check("R10", "ready_o", ready_o, 1'b1);
    rst_ni = 1'b1;
    cmp_en = 1'b1;

    cur_req = "R1";
    send(8'hA5, 7'h00); wait_idle();
    send(8'h96, 7'h01); wait_idle();
    send(8'h4B, 7'h02); wait_idle();
    send(8'hD2, 7'h03); wait_idle();

    cur_req = "R2";
    send(8'h00, 7'h03); send(8'hFF, 7'h03); wait_idle();

    cur_req = "R3";
    send(8'h15, 7'h04); wait_idle();
    send(8'h2A, 7'h05); wait_idle();
    send(8'h81, 7'h07); wait_idle();

    cur_req = "R4";
    send(8'h5A, 7'h33); wait_idle();

    cur_req = "R5";
    send(8'hE1, 7'h08); wait_idle();
    send(8'hE1, 7'h18); wait_idle();
    send(8'h6C, 7'h0B); wait_idle();
    send(8'h6C, 7'h1B); wait_idle();

    cur_req = "R6";
    send(8'h00, 7'h2B); wait_idle();
    send(8'hFF, 7'h3B); wait_idle();
    send(8'h33, 7'h29); wait_idle();

    cur_req = "R7";
    send(8'hC3, 7'h0B);
    repeat (200) @(negedge clk_i);
    ctrl_i[6] = 1'b1;
    repeat (150) @(negedge clk_i);
    ctrl_i[6] = 1'b0;
    wait_idle();
    ctrl_i[6] = 1'b1;
    repeat (20) @(negedge clk_i);
    ctrl_i[6] = 1'b0;
    repeat (5) @(negedge clk_i);

    cur_req = "R8";
    send(8'h3C, 7'h03);
    repeat (100) @(negedge clk_i);
    ctrl_i = 7'h3C; data_i = 8'hFF;
    wait_idle();

    cur_req = "R9";
    send(8'h55, 7'h1B);
    repeat (50) @(negedge clk_i);
    data_i = 8'h77; valid_i = 1'b1;
    repeat (30) @(negedge clk_i);
    valid_i = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk_i);

    finish_run();
  end
endmodule